// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator With Auto-Settle

This block turns the 1-bit output of a delta-sigma modulator into signed 24-bit conversion words. It runs from the oscillator clock and divides that clock down to the modulator rate on its own. Each modulator sample is read on that strobe, mapped to +1 or −1, and fed into a cascade of three integrators. Once every decimation period, comb stages at the output rate form a first-, second- or third-order sinc result.

The filter order is picked by a mode input. The fast filter settles in one output period and sinc2 in two. Sinc3 needs three periods and gives the lowest noise. An auto mode follows each channel change with one fast word, then one sinc2 word, then sinc3 words from then on, so the first word after a switch is already usable.

Every order is scaled onto the same 24-bit full-scale range. A channel-change pulse restarts the whole filter, so the first word after it carries no data from the previous channel.

Top module: `sinc_decimator`

## Requirements
- R1: While reset is held and right after it is released, `dready_o`, `settled_o` and `mod_stb_o` are low and `data_o` is zero.
- R2: `mod_stb_o` is high for exactly one clock in every M clocks, with M = 128 when `speed_i` is 0 and M = 256 when it is 1. It first rises after M−1 rising edges following reset release or a channel-change clock. `mod_bit_i` is sampled at the rising edge that ends a strobe clock.
- R3: The decimation ratio is R = 2^(`ratio_code_i` + 2), so codes 0 to 3 give 4, 8, 16 and 32. `dready_o` pulses high for one clock, two clocks after the strobe clock that takes sample number R, 2R, 3R and so on after a clear.
- R4: A sample bit of 1 counts as +1 and a bit of 0 counts as −1. An order-k result is multiplied by 2^(23 − k·log2 R) and clipped at 0x7FFFFF. A constant run of ones therefore settles to 0x7FFFFF, and a constant run of zeros settles to 0x800000.
- R5: With `fmode_i` = 0 (fast), each word is the sum of the last R samples, and `settled_o` is high on every word.
- R6: With `fmode_i` = 1 (sinc2), each word is the second-order sinc of the samples, with zeros assumed before the last clear. `settled_o` is low on the first word after a clear and high from the second word on.
- R7: With `fmode_i` = 2 (sinc3), each word is the third-order sinc. `settled_o` is low on the first two words after a clear and high from the third word on.
- R8: With `fmode_i` = 3 (auto), the first word after a clear is the order-1 result and the second is the order-2 result. Every later word is the order-3 result. `settled_o` is high on all of them.
- R9: A clock with `chan_i` high clears all filter state and restarts the clock divider, the decimation count and the word count. A strobe in that same clock is discarded, and a `dready_o` pulse due in the next clock is cancelled.
- R10: `data_o` and `settled_o` change only in the clock where `dready_o` is high, and they hold their values through every other clock, including a channel-change clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_bit_i | input | 1 | Modulator output bit |
| chan_i | input | 1 | Channel-change pulse; restarts the filter |
| speed_i | input | 1 | Modulator clock divide: 0 gives /128, 1 gives /256 |
| ratio_code_i | input | 2 | Decimation ratio code; R = 2^(code+2) |
| fmode_i | input | 2 | Filter mode: 0 fast, 1 sinc2, 2 sinc3, 3 auto |
| mod_stb_o | output | 1 | Modulator-rate strobe |
| data_o | output | 24 | Conversion word, two's complement |
| dready_o | output | 1 | One-clock pulse for each new word |
| settled_o | output | 1 | The current word is fully settled |

## Verification
The assertions on settling and on word pulses assume that `fmode_i`, `ratio_code_i` and `speed_i` change only in a clock where `chan_i` is high. They also assume that a word the filter is already producing is read against the mode in force when that word is formed. The bench follows this rule: every configuration change goes out together with a channel-change pulse, and between pulses only `mod_bit_i` moves. Some channel changes are timed to land exactly on a strobe clock or on a pending word, so the discard and cancel paths are covered.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;
  typedef enum logic [1:0] {
    FMODE_FAST  = 2'd0,
    FMODE_SINC2 = 2'd1,
    FMODE_SINC3 = 2'd2,
    FMODE_AUTO  = 2'd3
  } fmode_e;
endpackage

// File: rtl/sinc_dec_timing.sv
module sinc_dec_timing #(
  parameter int RATIO_LOG2_MIN = 2,
  parameter int RCODE_W        = 2,
  parameter int DIV_BASE_LOG2  = 7,
  localparam int LOG2_MAX      = RATIO_LOG2_MIN + (1 << RCODE_W) - 1,
  localparam int DEC_W         = LOG2_MAX,
  localparam int DIV_W         = DIV_BASE_LOG2 + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               speed_i,
  input  logic [RCODE_W-1:0] ratio_code_i,
  output logic               mod_stb_o,
  output logic               dump_o
);
  logic [DIV_W-1:0] div_q, div_last;
  logic [DEC_W-1:0] dec_q, dec_last;
  logic             dump_q;

  assign div_last  = speed_i ? '1 : {1'b0, {(DIV_W-1){1'b1}}};
  assign dec_last  = DEC_W'((1 << (RATIO_LOG2_MIN + int'(ratio_code_i))) - 1);
  assign mod_stb_o = (div_q == div_last);
  assign dump_o    = dump_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      dec_q  <= '0;
      dump_q <= 1'b0;
    end else if (clr_i) begin
      div_q  <= '0;
      dec_q  <= '0;
      dump_q <= 1'b0;
    end else begin
      div_q  <= mod_stb_o ? '0 : div_q + 1'b1;
      dump_q <= mod_stb_o && (dec_q == dec_last);
      if (mod_stb_o) dec_q <= (dec_q == dec_last) ? '0 : dec_q + 1'b1;
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_stb_o |=> !mod_stb_o); // R2
  AST_DUMP_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_o |-> $past(mod_stb_o)); // R3
endmodule

// File: rtl/sinc_dec_integ.sv
module sinc_dec_integ #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] acc1_o,
  output logic [W-1:0] acc2_o,
  output logic [W-1:0] acc3_o
);
  logic [W-1:0] x, n1, n2, n3;

  // chained sums without pipeline delay keep the response a pure boxcar power
  assign x  = bit_i ? W'(1) : '1;
  assign n1 = acc1_o + x;
  assign n2 = acc2_o + n1;
  assign n3 = acc3_o + n2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc1_o <= '0;
      acc2_o <= '0;
      acc3_o <= '0;
    end else if (clr_i) begin
      acc1_o <= '0;
      acc2_o <= '0;
      acc3_o <= '0;
    end else if (en_i) begin
      acc1_o <= n1;
      acc2_o <= n2;
      acc3_o <= n3;
    end
  end
endmodule

// File: rtl/sinc_dec_comb.sv
module sinc_dec_comb #(
  parameter int W     = 17,
  parameter int ORDER = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] tap [ORDER+1];

  assign tap[0] = in_i;

  for (genvar j = 0; j < ORDER; j++) begin : g_stage
    logic [W-1:0] dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q <= '0;
      else if (clr_i)  dly_q <= '0;
      else if (en_i)   dly_q <= tap[j];
    end
    assign tap[j+1] = tap[j] - dly_q;
  end

  assign out_o = tap[ORDER];
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_dec_pkg::*;
#(
  parameter int RATIO_LOG2_MIN = 2,
  parameter int RCODE_W        = 2,
  parameter int DIV_BASE_LOG2  = 7,
  parameter int OUT_W          = 24,
  localparam int LOG2_MAX      = RATIO_LOG2_MIN + (1 << RCODE_W) - 1,
  localparam int INT_W         = 3 * LOG2_MAX + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mod_bit_i,
  input  logic               chan_i,
  input  logic               speed_i,
  input  logic [RCODE_W-1:0] ratio_code_i,
  input  logic [1:0]         fmode_i,
  output logic               mod_stb_o,
  output logic [OUT_W-1:0]   data_o,
  output logic               dready_o,
  output logic               settled_o
);
  localparam logic signed [OUT_W:0] POS_MAX = (OUT_W+1)'((1 << (OUT_W-1)) - 1);

  logic             dump;
  logic [INT_W-1:0] acc [3];
  logic [INT_W-1:0] res [3];
  logic [1:0]       cnt_q;
  fmode_e           mode;
  int               order, shamt;
  logic             settle_now;
  logic [INT_W-1:0] sel;
  logic signed [OUT_W:0] ext, scaled;
  logic [OUT_W-1:0] word;

  sinc_dec_timing #(
    .RATIO_LOG2_MIN(RATIO_LOG2_MIN), .RCODE_W(RCODE_W), .DIV_BASE_LOG2(DIV_BASE_LOG2)
  ) u_timing (
    .clk_i, .rst_ni, .clr_i(chan_i), .speed_i, .ratio_code_i,
    .mod_stb_o, .dump_o(dump)
  );

  sinc_dec_integ #(.W(INT_W)) u_integ (
    .clk_i, .rst_ni, .clr_i(chan_i), .en_i(mod_stb_o), .bit_i(mod_bit_i),
    .acc1_o(acc[0]), .acc2_o(acc[1]), .acc3_o(acc[2])
  );

  for (genvar k = 0; k < 3; k++) begin : g_comb
    sinc_dec_comb #(.W(INT_W), .ORDER(k + 1)) u_comb (
      .clk_i, .rst_ni, .clr_i(chan_i), .en_i(dump), .in_i(acc[k]), .out_o(res[k])
    );
  end

  assign mode = fmode_e'(fmode_i);

  always_comb begin
    unique case (mode)
      FMODE_FAST:  begin order = 1; settle_now = 1'b1;          end
      FMODE_SINC2: begin order = 2; settle_now = (cnt_q >= 2'd1); end
      FMODE_SINC3: begin order = 3; settle_now = (cnt_q >= 2'd2); end
      default:     begin order = (cnt_q == 2'd0) ? 1 : (cnt_q == 2'd1) ? 2 : 3;
                         settle_now = 1'b1; end
    endcase
    shamt  = OUT_W - 1 - order * (RATIO_LOG2_MIN + int'(ratio_code_i));
    sel    = res[order-1];
    ext    = $signed({{(OUT_W+1-INT_W){sel[INT_W-1]}}, sel});
    scaled = ext <<< shamt;
    word   = (scaled > POS_MAX) ? POS_MAX[OUT_W-1:0] : scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      settled_o <= 1'b0;
      dready_o  <= 1'b0;
      cnt_q     <= '0;
    end else begin
      dready_o <= dump && !chan_i;
      if (chan_i) begin
        cnt_q <= '0;
      end else if (dump) begin
        data_o    <= word;
        settled_o <= settle_now;
        if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  AST_DRDY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dready_o |=> !dready_o); // R3
  AST_CHAN_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_i |=> !dready_o); // R9
  AST_FAST_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump && !chan_i && mode == FMODE_FAST) |=> (dready_o && settled_o)); // R5
  AST_AUTO_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump && !chan_i && mode == FMODE_AUTO) |=> (dready_o && settled_o)); // R8
  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dready_o |-> $stable(data_o)); // R10
endmodule

// File: tb/sinc_decimator_test.sv
module sinc_decimator_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mod_bit_i = 1'b0;
  logic        chan_i = 1'b0;
  logic        speed_i = 1'b0;
  logic [1:0]  ratio_code_i = 2'd0;
  logic [1:0]  fmode_i = 2'd0;
  logic        mod_stb_o, dready_o, settled_o;
  logic [23:0] data_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string sec_tag = "R5";

  int    xs[$];
  int    bdiv = 0, nsamp = 0, cnt = 0;
  bit    dump_pend = 0;
  logic  exp_stb = 0, exp_drdy = 0, exp_set = 0;
  logic [23:0] exp_data = '0;

  always #2 clk = ~clk;

  sinc_decimator uut (
    .clk_i(clk), .rst_ni, .mod_bit_i, .chan_i, .speed_i, .ratio_code_i, .fmode_i,
    .mod_stb_o, .data_o, .dready_o, .settled_o
  );

  function automatic longint sinc_val(int k, int r);
    int n = xs.size();
    int a[], b[];
    a = new[n];
    foreach (a[i]) a[i] = xs[i];
    for (int s = 0; s < k; s++) begin
      b = new[n];
      for (int t = 0; t < n; t++) begin
        int acc = 0;
        for (int j = 0; j < r && j <= t; j++) acc += a[t-j];
        b[t] = acc;
      end
      a = b;
    end
    return longint'(a[n-1]);
  endfunction

  task automatic model(input logic b, input logic ch);
    int m = speed_i ? 256 : 128;
    int l = 2 + int'(ratio_code_i);
    int r = 1 << l;
    bit stb_now = (bdiv == m - 1);
    if (ch) begin
      bdiv = 0; nsamp = 0; cnt = 0; dump_pend = 0; exp_drdy = 0;
      xs.delete();
    end else begin
      exp_drdy = dump_pend;
      if (dump_pend) begin
        int k;
        longint v;
        case (fmode_i)
          2'd0: begin k = 1; exp_set = 1; end
          2'd1: begin k = 2; exp_set = (cnt >= 1); end
          2'd2: begin k = 3; exp_set = (cnt >= 2); end
          default: begin k = (cnt == 0) ? 1 : (cnt == 1) ? 2 : 3; exp_set = 1; end
        endcase
        v = sinc_val(k, r) * (longint'(1) << (23 - k * l));
        if (v > 64'sd8388607) v = 64'sd8388607;
        exp_data = 24'(v);
        if (cnt < 3) cnt++;
      end
      dump_pend = stb_now && ((nsamp % r) == r - 1);
      if (stb_now) begin
        xs.push_back(b ? 1 : -1);
        nsamp++;
        if (xs.size() > 128) void'(xs.pop_front());
      end
      bdiv = stb_now ? 0 : bdiv + 1;
    end
    exp_stb = (bdiv == m - 1);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    vectors++;
    check("R2", "mod_stb_o", 32'(mod_stb_o), 32'(exp_stb));
    check("R3", "dready_o", 32'(dready_o), 32'(exp_drdy));
    check(sec_tag, "data_o", 32'(data_o), 32'(exp_data));
    check(sec_tag, "settled_o", 32'(settled_o), 32'(exp_set));
  endtask

  task automatic cycle(input logic b, input logic ch);
    mod_bit_i = b;
    chan_i    = ch;
    model(b, ch);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n, input int dens);
    for (int i = 0; i < n; i++) cycle(logic'($urandom_range(99) < dens), 1'b0);
  endtask

  task automatic chan_cfg(input logic [1:0] m, input logic [1:0] c, input logic s);
    fmode_i = m; ratio_code_i = c; speed_i = s;
    cycle(1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R3 watchdog expired before the run completed");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    vectors++;
    check("R1", "dready_o in reset", 32'(dready_o), 32'd0);
    check("R1", "data_o in reset", 32'(data_o), 32'd0);
    rst_ni = 1'b1;
    vectors++;
    check("R1", "mod_stb_o after release", 32'(mod_stb_o), 32'd0);
    check("R1", "settled_o after release", 32'(settled_o), 32'd0);
    check("R1", "data_o after release", 32'(data_o), 32'd0);

    // R5: fast filter straight out of reset, ratio 4
    sec_tag = "R5";
    run(5 * 512, 70);

    // R4: full-scale positive and negative through sinc3
    sec_tag = "R4";
    chan_cfg(2'd2, 2'd0, 1'b0);
    run(5 * 512, 100);
    chan_cfg(2'd2, 2'd0, 1'b0);
    run(5 * 512, 0);

    // R6: sinc2, ratio 8
    sec_tag = "R6";
    chan_cfg(2'd1, 2'd1, 1'b0);
    run(5 * 1024, 30);

    // R7: sinc3, ratio 4, slow modulator clock
    sec_tag = "R7";
    chan_cfg(2'd2, 2'd0, 1'b1);
    run(6 * 1024, 80);

    // R8: auto sequencing at two ratios and speeds
    sec_tag = "R8";
    chan_cfg(2'd3, 2'd2, 1'b0);
    run(5 * 2048, 60);
    chan_cfg(2'd3, 2'd3, 1'b1);
    run(4 * 8192 + 16, 45);

    // R9: channel changes at arbitrary points, on a strobe and on a pending word
    sec_tag = "R9";
    for (int i = 0; i < 8; i++) begin
      chan_cfg(2'd3, 2'd0, 1'b0);
      run(int'($urandom_range(1500, 100)), 55);
    end
    chan_cfg(2'd3, 2'd0, 1'b0);
    run(127, 50);
    cycle(1'b1, 1'b1);
    run(700, 50);
    while (!dump_pend) cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b1);
    run(3000, 65);

    // R10: words hold between pulses
    sec_tag = "R10";
    chan_cfg(2'd0, 2'd0, 1'b0);
    run(2000, 50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule